// File: doc/BRIEF.md
# Streaming Read Data Ports

This block serves two read-side data streams to a sequencing core. The memory stream presents a 64-bit dword address to a memory read port and hands back the dword found there. The register stream presents a register index to a register file read port and hands back that register's value. Each stream has its own pointer and a count of dwords still to be delivered. A consuming read moves the pointer forward and lowers the count. A peek read returns the same word and leaves the stream where it was.

The memory stream has a privileged mode, controlled by a separate high-word register. When its top bit is set, the upper half of the memory address comes from that register and not from the pointer's upper word. Pointer arithmetic is then confined to the lower 32 bits. Pointers, counts and the privileged word are loaded through a small configuration write port. The memory and register read ports answer combinationally. Each result is registered and flagged valid in the cycle after its strobe.

Top module: `stream_rd_ports`

## Requirements
- R1: After reset both counts, both pointers and the privileged word are zero, `mem_addr` is zero and both valid flags are low.
- R2: A memory read returns the dword at `mem_addr`. If the read is not a peek and the count is nonzero, the count drops by one and the 64-bit pointer grows by 4, with carry from the low word into the high word.
- R3: While bit 31 of the privileged word is set, `mem_addr` is the pointer's low word in bits 31:0, the privileged word's bits 30:0 in bits 62:32, and zero in bit 63.
- R4: In privileged mode a consuming read adds 4 to the pointer's low word only. It wraps without carry, and the pointer's high word is unchanged.
- R5: On either stream, a read while the count is zero still returns data but changes neither the pointer nor the count.
- R6: A read with `rd_peek` high returns the current word and changes neither the pointer nor the count of that stream.
- R7: A consuming register read with a nonzero count returns the register at the pointer, drops the count by one and adds 1 to the pointer.
- R8: A register read whose pointer is at or above `NREG` returns zero.
- R9: `mem_data`/`reg_data` and `mem_vld`/`reg_vld` update in the cycle after a strobe. The valid flag is high for exactly the cycles that follow a strobe.
- R10: The `cfg_sel` codes are: 0 memory count, 1 memory pointer low, 2 memory pointer high, 3 privileged word, 4 register count, 5 register pointer. A configuration write to a field takes priority over a stream advance of that same field in the same cycle. Other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration field select (see R10) |
| cfg_wdata | input | 32 | Configuration write data |
| mem_rd | input | 1 | Memory stream read strobe |
| reg_rd | input | 1 | Register stream read strobe |
| rd_peek | input | 1 | Marks this cycle's reads as non-consuming |
| mem_addr | output | 64 | Effective memory read address |
| mem_rdata | input | 32 | Memory read data for `mem_addr` |
| mem_data | output | 32 | Registered memory stream result |
| mem_vld | output | 1 | Memory result valid |
| mem_left | output | CW | Memory stream remaining count |
| reg_addr | output | clog2(NREG) | Register read index |
| reg_rdata | input | 32 | Register read data for `reg_addr` |
| reg_data | output | 32 | Registered register stream result |
| reg_vld | output | 1 | Register result valid |
| reg_left | output | CW | Register stream remaining count |

## Verification
The memory stream is started just below a 4 GB boundary so that the second word shows whether the carry reaches the high word. The same start is then repeated in privileged mode, where the low word must wrap and leave the high word alone. Reads run past the end of each count and compare repeated results, which separates a stream that stops from one that keeps advancing. Peek reads are interleaved with consuming ones. The register pointer is walked across the last implemented index to show the change to zero data. A configuration write is issued in the same cycle as a consuming read, which shows the write taking priority on its own field while the pointer still advances.

// File: rtl/srp_pkg.sv
package srp_pkg;
    typedef enum logic [2:0] {
        SEL_MCNT  = 3'd0,
        SEL_MLO   = 3'd1,
        SEL_MHI   = 3'd2,
        SEL_MPRIV = 3'd3,
        SEL_RCNT  = 3'd4,
        SEL_RADR  = 3'd5
    } cfg_sel_e;
endpackage

// File: rtl/srp_mem_port.sv
module srp_mem_port
    import srp_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  cfg_sel_e        cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            rd_stb,
    input  logic            rd_peek,
    output logic [2*DW-1:0] mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   rd_data,
    output logic            rd_vld,
    output logic [CW-1:0]   left
);
    localparam int PB = DW - 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] lo;
        logic [DW-1:0] hi;
        logic [DW-1:0] priv;
        logic [DW-1:0] data;
        logic          vld;
    } st_t;

    st_t st_d, st_q;
    logic            priv_on;
    logic            adv;
    logic [2*DW-1:0] wide_nxt;

    always_comb begin
        priv_on  = st_q.priv[PB];
        mem_addr = priv_on ? {1'b0, st_q.priv[PB-1:0], st_q.lo} : {st_q.hi, st_q.lo};
        wide_nxt = {st_q.hi, st_q.lo} + (2*DW)'(4);
        adv      = rd_stb && !rd_peek && (st_q.cnt != '0);
        st_d     = st_q;
        st_d.vld = rd_stb;
        if (rd_stb) st_d.data = mem_rdata;
        if (adv) begin
            st_d.cnt = st_q.cnt - CW'(1);
            if (priv_on) st_d.lo = st_q.lo + DW'(4);
            else         {st_d.hi, st_d.lo} = wide_nxt;
        end
        if (cfg_we) begin
            case (cfg_sel)
                SEL_MCNT:  st_d.cnt  = cfg_wdata[CW-1:0];
                SEL_MLO:   st_d.lo   = cfg_wdata;
                SEL_MHI:   st_d.hi   = cfg_wdata;
                SEL_MPRIV: st_d.priv = cfg_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;
    assign rd_vld  = st_q.vld;
    assign left    = st_q.cnt;

    // R2
    mem_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !rd_peek && st_q.cnt != '0 && !cfg_we |=> st_q.cnt == $past(st_q.cnt) - CW'(1));
    // R4
    priv_nocarry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !rd_peek && st_q.cnt != '0 && st_q.priv[PB] && !cfg_we |=> $stable(st_q.hi));
    // R5
    mem_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && st_q.cnt == '0 && !cfg_we |=> $stable(st_q.lo) && $stable(st_q.hi) && st_q.cnt == '0);
    // R6
    mem_peek_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && rd_peek && !cfg_we |=> $stable(mem_addr) && $stable(st_q.cnt));
    // R9
    mem_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> rd_vld);
endmodule

// File: rtl/srp_reg_port.sv
module srp_reg_port
    import srp_pkg::*;
#(
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int NREG = 1024,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  cfg_sel_e       cfg_sel,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic           rd_stb,
    input  logic           rd_peek,
    output logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_rdata,
    output logic [DW-1:0]  rd_data,
    output logic           rd_vld,
    output logic [CW-1:0]  left
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] adr;
        logic [DW-1:0] data;
        logic          vld;
    } st_t;

    st_t  st_d, st_q;
    logic in_range;
    logic adv;

    always_comb begin
        reg_addr = st_q.adr[RAW-1:0];
        in_range = st_q.adr < DW'(NREG);
        adv      = rd_stb && !rd_peek && (st_q.cnt != '0);
        st_d     = st_q;
        st_d.vld = rd_stb;
        if (rd_stb) st_d.data = in_range ? reg_rdata : '0;
        if (adv) begin
            st_d.cnt = st_q.cnt - CW'(1);
            st_d.adr = st_q.adr + DW'(1);
        end
        if (cfg_we) begin
            case (cfg_sel)
                SEL_RCNT: st_d.cnt = cfg_wdata[CW-1:0];
                SEL_RADR: st_d.adr = cfg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.data;
    assign rd_vld  = st_q.vld;
    assign left    = st_q.cnt;

    // R7
    reg_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && !rd_peek && st_q.cnt != '0 && !cfg_we |=> st_q.adr == $past(st_q.adr) + DW'(1));
    // R8
    reg_range_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && st_q.adr >= DW'(NREG) |=> rd_data == '0);
    // R6
    reg_peek_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb && rd_peek && !cfg_we |=> $stable(st_q.adr) && $stable(st_q.cnt));
    // R9
    reg_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> !rd_vld);
endmodule

// File: rtl/stream_rd_ports.sv
module stream_rd_ports
    import srp_pkg::*;
#(
    parameter int DW   = 32,
    parameter int CW   = 16,
    parameter int NREG = 1024,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [2:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            mem_rd,
    input  logic            reg_rd,
    input  logic            rd_peek,
    output logic [2*DW-1:0] mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_data,
    output logic            mem_vld,
    output logic [CW-1:0]   mem_left,
    output logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_rdata,
    output logic [DW-1:0]   reg_data,
    output logic            reg_vld,
    output logic [CW-1:0]   reg_left
);
    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    srp_mem_port #(.DW(DW), .CW(CW)) u_mem (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(sel), .cfg_wdata(cfg_wdata),
        .rd_stb(mem_rd), .rd_peek(rd_peek), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .rd_data(mem_data), .rd_vld(mem_vld), .left(mem_left)
    );

    srp_reg_port #(.DW(DW), .CW(CW), .NREG(NREG)) u_reg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(sel), .cfg_wdata(cfg_wdata),
        .rd_stb(reg_rd), .rd_peek(rd_peek), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .rd_data(reg_data), .rd_vld(reg_vld), .left(reg_left)
    );
endmodule

// File: tb/sim_stream_rd_ports.sv
`timescale 1ns/1ps
module sim_stream_rd_ports;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        mem_rd = 1'b0, reg_rd = 1'b0, rd_peek = 1'b0;
    logic [63:0] mem_addr;
    logic [31:0] mem_rdata, mem_data, reg_rdata, reg_data;
    logic        mem_vld, reg_vld;
    logic [15:0] mem_left, reg_left;
    logic [9:0]  reg_addr;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] mfun(input logic [63:0] a);
        return a[31:0] ^ a[63:32] ^ 32'h5A5A_0000;
    endfunction
    function automatic logic [31:0] gfun(input logic [31:0] a);
        return a * 3 + 7;
    endfunction

    assign mem_rdata = mfun(mem_addr);
    assign reg_rdata = gfun(32'(reg_addr));

    stream_rd_ports u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_rd(mem_rd), .reg_rd(reg_rd), .rd_peek(rd_peek), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_data(mem_data), .mem_vld(mem_vld), .mem_left(mem_left),
        .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_data(reg_data), .reg_vld(reg_vld),
        .reg_left(reg_left)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic rd(input bit is_mem, input bit pk);
        @(negedge clk); mem_rd = is_mem; reg_rd = !is_mem; rd_peek = pk;
        @(negedge clk); mem_rd = 1'b0; reg_rd = 1'b0; rd_peek = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mem_left", 64'(mem_left), 64'd0);
        chk("R1 reg_left", 64'(reg_left), 64'd0);
        chk("R1 mem_addr", mem_addr, 64'd0);
        chk("R1 vld", {62'd0, mem_vld, reg_vld}, 64'd0);
    endtask

    task automatic t_mem_carry();
        cfg(3'd1, 32'hFFFF_FFFC); cfg(3'd2, 32'd1); cfg(3'd0, 32'd2);
        rd(1'b1, 1'b0);
        chk("R2 data", 64'(mem_data), 64'(mfun(64'h1_FFFF_FFFC)));
        chk("R9 mem_vld", 64'(mem_vld), 64'd1);
        chk("R2 left", 64'(mem_left), 64'd1);
        chk("R2 carry addr", mem_addr, 64'h2_0000_0000);
        rd(1'b1, 1'b0);
        chk("R2 data2", 64'(mem_data), 64'(mfun(64'h2_0000_0000)));
        chk("R2 left2", 64'(mem_left), 64'd0);
        chk("R2 addr2", mem_addr, 64'h2_0000_0004);
        rd(1'b1, 1'b0);
        chk("R5 mem data at zero", 64'(mem_data), 64'(mfun(64'h2_0000_0004)));
        chk("R5 mem addr hold", mem_addr, 64'h2_0000_0004);
        chk("R5 mem left hold", 64'(mem_left), 64'd0);
        @(negedge clk);
        chk("R9 vld drops", 64'(mem_vld), 64'd0);
    endtask

    task automatic t_peek();
        cfg(3'd0, 32'd3);
        rd(1'b1, 1'b1);
        chk("R6 peek data", 64'(mem_data), 64'(mfun(64'h2_0000_0004)));
        chk("R6 peek left", 64'(mem_left), 64'd3);
        chk("R6 peek addr", mem_addr, 64'h2_0000_0004);
        rd(1'b1, 1'b0);
        chk("R6 consume after peek", mem_addr, 64'h2_0000_0008);
        chk("R6 left after consume", 64'(mem_left), 64'd2);
    endtask

    task automatic t_priv();
        cfg(3'd3, 32'h8000_0007); cfg(3'd1, 32'hFFFF_FFFC); cfg(3'd2, 32'd5); cfg(3'd0, 32'd1);
        chk("R3 priv addr", mem_addr, 64'h7_FFFF_FFFC);
        rd(1'b1, 1'b0);
        chk("R3 priv data", 64'(mem_data), 64'(mfun(64'h7_FFFF_FFFC)));
        chk("R4 priv wrap", mem_addr, 64'h7_0000_0000);
        chk("R4 left", 64'(mem_left), 64'd0);
        cfg(3'd3, 32'd0);
        chk("R4 hi untouched", mem_addr, 64'h5_0000_0000);
    endtask

    task automatic t_reg();
        cfg(3'd5, 32'd10); cfg(3'd4, 32'd2);
        rd(1'b0, 1'b0);
        chk("R7 data", 64'(reg_data), 64'd37);
        chk("R7 left", 64'(reg_left), 64'd1);
        chk("R9 reg_vld", 64'(reg_vld), 64'd1);
        rd(1'b0, 1'b1);
        chk("R6 reg peek", 64'(reg_data), 64'd40);
        chk("R6 reg peek left", 64'(reg_left), 64'd1);
        rd(1'b0, 1'b0);
        chk("R7 data2", 64'(reg_data), 64'd40);
        chk("R7 left2", 64'(reg_left), 64'd0);
        rd(1'b0, 1'b0);
        chk("R5 reg data at zero", 64'(reg_data), 64'd43);
        rd(1'b0, 1'b0);
        chk("R5 reg addr hold", 64'(reg_data), 64'd43);
    endtask

    task automatic t_range();
        cfg(3'd5, 32'd1023); cfg(3'd4, 32'd2);
        rd(1'b0, 1'b0);
        chk("R8 last in range", 64'(reg_data), 64'd3076);
        rd(1'b0, 1'b0);
        chk("R8 beyond range", 64'(reg_data), 64'd0);
        chk("R8 left", 64'(reg_left), 64'd0);
    endtask

    task automatic t_prio();
        cfg(3'd1, 32'h100); cfg(3'd2, 32'd0); cfg(3'd0, 32'd1);
        @(negedge clk); mem_rd = 1'b1; cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 32'd9;
        @(negedge clk); mem_rd = 1'b0; cfg_we = 1'b0;
        chk("R10 cfg wins count", 64'(mem_left), 64'd9);
        chk("R10 addr still advances", mem_addr, 64'h104);
        chk("R10 data", 64'(mem_data), 64'(mfun(64'h100)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mem_carry();
        t_peek();
        t_priv();
        t_reg();
        t_range();
        t_prio();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule